// File: doc/BRIEF.md
# Grouped Byte Instruction Sequencer

This block is the front end of a byte-coded processor. It fetches one 32-bit group at a time. Each group holds four one-byte opcodes, and the block issues them one per cycle to the execution stage, starting with the leftmost byte. Operands are never encoded inside an opcode. A byte immediate always comes from the rightmost byte of the group. Word immediates come from the whole 32-bit words that follow the group. Both kinds of constant therefore sit at naturally aligned positions.

The sequencer also works out the address of the next group and skips over any constant words the current group used. It handles branches: once it has issued a branch opcode, it samples the branch outcome. On a taken branch it drops the rest of the group and fetches from the target. Memory is reached through a single request/valid port with variable latency, and the sequencer stalls while a word it needs is still outstanding. Slots are numbered 0 to 3, and slot 0 is bits 31:24 of the group.

Top module: `gbs_sequencer`

## Requirements
- R1: A fetch holds `mem_req` high with `mem_addr` unchanged until the cycle in which `mem_rvalid` is high, and the data is taken from `mem_rdata` in that cycle.
- R2: The slots of a group are issued in the order slot 0, 1, 2, 3, with slot 0 taken from bits 31:24. Each issue is a one-cycle `iss_valid` pulse carrying the slot number and the address of the group.
- R3: The load-byte opcode is 0x01. When it sits in slot 0, 1 or 2, its immediate is bits 7:0 of the group, zero-extended. In such a group, slot 3 is data and is never issued.
- R4: A load-byte opcode in slot 3 is issued as an ordinary opcode with immediate 0. Every opcode other than load-byte and load-word is issued with its byte unchanged and immediate 0. This covers no-op 0x00, branch 0x03, the ALU class 0x10 to 0x1F, and any other value.
- R5: The load-word opcode is 0x02. The k-th load-word of a group (counting from 0) gets as its immediate the word at group address + 4 + 4k. It is not issued until that word has returned.
- R6: When the last slot of a group has been handled and no branch was taken, the next group is fetched from group address + 4 + 4 × (the number of load-word opcodes in the group).
- R7: A branch (0x03) is issued, and in the next cycle `br_taken` and `br_target` are sampled. If the branch is taken, the remaining slots are dropped and the next group is fetched from `br_target` with bits 1:0 cleared, starting again at slot 0.
- R8: If a branch is not taken, sequencing continues with the next slot, or with the next group if the branch was in the group's last slot.
- R9: During and right after reset, nothing is issued and the first fetch is from address `RESET_ADDR` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Fetch request, held until data returns |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Requested word is on `mem_rdata` this cycle |
| mem_rdata | input | 8*SLOTS | Returned word |
| br_taken | input | 1 | Branch outcome, sampled the cycle after a branch issue |
| br_target | input | AW | Branch destination, sampled with `br_taken` |
| iss_valid | output | 1 | An opcode is issued this cycle |
| iss_op | output | 8 | Issued opcode byte |
| iss_imm | output | 8*SLOTS | Immediate for the issued opcode |
| iss_slot | output | $clog2(SLOTS) | Slot the opcode came from |
| iss_gaddr | output | AW | Address of the group the opcode came from |

## Verification
The assertions assume that memory returns data only while a request is pending, and never in the cycle right after it returned data for the previous request. They also assume the branch inputs matter only in the cycle after a branch issue. The bench memory responds only to a pending request, after a latency that varies from 0 to 3 cycles. It clears `mem_rvalid` for at least one cycle between responses. The bench drives `br_taken` only after it has seen a branch on the issue port, and clears it otherwise. It alternates taken and not-taken branches, and it gives one of the targets non-zero low bits so the alignment rule is exercised.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_LDB = 8'h01;
  localparam logic [7:0] OP_LDW = 8'h02;
  localparam logic [7:0] OP_BR  = 8'h03;

  typedef enum logic [1:0] {
    ST_GRP   = 2'd0,
    ST_SLOT  = 2'd1,
    ST_CONST = 2'd2,
    ST_BR    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/gbs_group_decode.sv
module gbs_group_decode #(
  parameter int SLOTS = 4,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic [8*SLOTS-1:0] grp,
  input  logic [SW-1:0]      slot,
  output logic [7:0]         cur_op,
  output logic               has_ldb,
  output logic [SW-1:0]      last_slot
);
  import gbs_pkg::*;

  logic [7:0]       ops [SLOTS];
  logic [SLOTS-2:0] ldb_lead;

  // slot 0 is the leftmost (most significant) byte
  for (genvar g = 0; g < SLOTS; g++) begin : g_split
    assign ops[g] = grp[8*(SLOTS-g)-1 -: 8];
  end

  // a load-byte in any slot but the last turns the last byte into data
  for (genvar g = 0; g < SLOTS-1; g++) begin : g_ldb
    assign ldb_lead[g] = (grp[8*(SLOTS-g)-1 -: 8] == OP_LDB);
  end

  assign has_ldb   = |ldb_lead;
  assign last_slot = has_ldb ? SW'(SLOTS-2) : SW'(SLOTS-1);
  assign cur_op    = ops[slot];
endmodule

// File: rtl/gbs_imm_sel.sv
module gbs_imm_sel #(
  parameter int SLOTS = 4,
  localparam int SW = $clog2(SLOTS),
  localparam int DW = 8*SLOTS
) (
  input  logic [7:0]    op,
  input  logic [SW-1:0] slot,
  input  logic [7:0]    tail_byte,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] imm
);
  import gbs_pkg::*;

  always_comb begin
    imm = '0;
    if (op == OP_LDW)
      imm = word_in;
    else if (op == OP_LDB && slot != SW'(SLOTS-1))
      imm = {{(DW-8){1'b0}}, tail_byte};
  end
endmodule

// File: rtl/gbs_addr_unit.sv
module gbs_addr_unit #(
  parameter int AW    = 32,
  parameter int SLOTS = 4,
  localparam int CW = $clog2(SLOTS+1),
  localparam int BW = $clog2(SLOTS)
) (
  input  logic [AW-1:0] grp_addr,
  input  logic [CW-1:0] ldw_cnt,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] tgt_addr
);
  localparam logic [AW-1:0] GRP_BYTES = AW'(SLOTS);

  // address of the next constant word, which equals the next group
  // address once every load-word of the group has been counted
  assign seq_addr = grp_addr + GRP_BYTES + (AW'(ldw_cnt) << BW);
  assign tgt_addr = br_target & ~AW'(SLOTS-1);
endmodule

// File: rtl/gbs_sequencer.sv
module gbs_sequencer #(
  parameter int          AW         = 32,
  parameter int          SLOTS      = 4,
  parameter logic [31:0] RESET_ADDR = 32'h0,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS+1),
  localparam int DW = 8*SLOTS
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  output logic          iss_valid,
  output logic [7:0]    iss_op,
  output logic [DW-1:0] iss_imm,
  output logic [SW-1:0] iss_slot,
  output logic [AW-1:0] iss_gaddr
);
  import gbs_pkg::*;

  seq_state_t    state;
  logic [AW-1:0] grp_addr;
  logic [DW-1:0] grp_word;
  logic [SW-1:0] slot;
  logic [CW-1:0] ldw_cnt;

  logic [7:0]    cur_op;
  logic          has_ldb;
  logic [SW-1:0] last_slot;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] imm_val;
  logic          at_last;

  gbs_group_decode #(.SLOTS(SLOTS)) u_dec (
    .grp       (grp_word),
    .slot      (slot),
    .cur_op    (cur_op),
    .has_ldb   (has_ldb),
    .last_slot (last_slot)
  );

  gbs_imm_sel #(.SLOTS(SLOTS)) u_imm (
    .op        (cur_op),
    .slot      (slot),
    .tail_byte (grp_word[7:0]),
    .word_in   (mem_rdata),
    .imm       (imm_val)
  );

  gbs_addr_unit #(.AW(AW), .SLOTS(SLOTS)) u_addr (
    .grp_addr  (grp_addr),
    .ldw_cnt   (ldw_cnt),
    .br_target (br_target),
    .seq_addr  (seq_addr),
    .tgt_addr  (tgt_addr)
  );

  assign at_last  = (slot == last_slot);
  assign mem_req  = (state == ST_GRP) || (state == ST_CONST);
  assign mem_addr = (state == ST_GRP) ? grp_addr : seq_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_GRP;
      grp_addr  <= RESET_ADDR[AW-1:0];
      grp_word  <= '0;
      slot      <= '0;
      ldw_cnt   <= '0;
      iss_valid <= 1'b0;
      iss_op    <= OP_NOP;
      iss_imm   <= '0;
      iss_slot  <= '0;
      iss_gaddr <= '0;
    end else begin
      iss_valid <= 1'b0;
      case (state)
        ST_GRP: begin
          if (mem_rvalid) begin
            grp_word <= mem_rdata;
            slot     <= '0;
            ldw_cnt  <= '0;
            state    <= ST_SLOT;
          end
        end
        ST_SLOT: begin
          if (cur_op == OP_LDW) begin
            state <= ST_CONST;
          end else begin
            iss_valid <= 1'b1;
            iss_op    <= cur_op;
            iss_imm   <= imm_val;
            iss_slot  <= slot;
            iss_gaddr <= grp_addr;
            if (cur_op == OP_BR) begin
              state <= ST_BR;
            end else if (at_last) begin
              grp_addr <= seq_addr;
              state    <= ST_GRP;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        ST_CONST: begin
          if (mem_rvalid) begin
            iss_valid <= 1'b1;
            iss_op    <= cur_op;
            iss_imm   <= imm_val;
            iss_slot  <= slot;
            iss_gaddr <= grp_addr;
            ldw_cnt   <= ldw_cnt + 1'b1;
            if (at_last) begin
              grp_addr <= seq_addr + AW'(SLOTS);
              state    <= ST_GRP;
            end else begin
              slot  <= slot + 1'b1;
              state <= ST_SLOT;
            end
          end
        end
        ST_BR: begin
          if (br_taken) begin
            grp_addr <= tgt_addr;
            state    <= ST_GRP;
          end else if (at_last) begin
            grp_addr <= seq_addr;
            state    <= ST_GRP;
          end else begin
            slot  <= slot + 1'b1;
            state <= ST_SLOT;
          end
        end
        default: state <= ST_GRP;
      endcase
    end
  end

  // R1: an open request keeps its address until data returns
  p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R5: the returned constant is issued on the next cycle
  p_const_imm_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONST && mem_rvalid) |=> (iss_valid && iss_imm == $past(mem_rdata)));

  // R3: the data byte of a load-byte group is never issued
  p_no_data_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && has_ldb) |-> (iss_slot != SW'(SLOTS-1)));

  // R3: load-byte immediate is the zero-extended tail byte
  p_ldb_imm_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_op == OP_LDB && iss_slot != SW'(SLOTS-1))
      |-> (iss_imm == {{(DW-8){1'b0}}, grp_word[7:0]}));

  // R7: a taken branch refetches from the aligned target
  p_br_refetch_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BR && br_taken)
      |=> (mem_req && mem_addr == ($past(br_target) & ~AW'(SLOTS-1))));
endmodule

// File: tb/tb_gbs_sequencer.sv
module tb_gbs_sequencer;
  localparam int AW   = 32;
  localparam int NISS = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata  = '0;
  logic        br_taken   = 1'b0;
  logic [31:0] br_target  = '0;
  logic        iss_valid;
  logic [7:0]  iss_op;
  logic [31:0] iss_imm;
  logic [1:0]  iss_slot;
  logic [31:0] iss_gaddr;

  gbs_sequencer #(.AW(AW), .SLOTS(4)) dut (
    .clk, .rst, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .br_taken, .br_target, .iss_valid, .iss_op, .iss_imm,
    .iss_slot, .iss_gaddr
  );

  always #10 clk = ~clk;

  logic [31:0] ram [64];
  logic [7:0]  q_op [$];
  logic [31:0] q_imm [$];
  int          q_slot [$];
  logic [31:0] q_ga [$];
  string       q_tag [$];
  logic [31:0] q_fa [$];
  string       q_ftag [$];

  int tests = 0;
  int fails = 0;
  int seen  = 0;
  int cyc   = 0;

  function automatic logic [31:0] tgt_of(int n);
    case (n % 3)
      0:       return 32'h30;
      1:       return 32'h4A;  // unaligned on purpose
      default: return 32'h00;
    endcase
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a);
    return ram[(a >> 2) % 64];
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: walk the program and list issues and fetches
  task automatic build_model();
    logic [31:0] pc = 0;
    int          brn = 0;
    int          niss = 0;
    string       entry_tag = "R9";
    while (niss < NISS + 8) begin
      logic [31:0] w;
      bit          hasl;
      int          nl;
      bit          taken;
      w = rd(pc);
      q_fa.push_back(pc);
      q_ftag.push_back(entry_tag);
      hasl  = (w[31:24] == 8'h01) || (w[23:16] == 8'h01) || (w[15:8] == 8'h01);
      nl    = 0;
      taken = 0;
      for (int s = 0; s < 4; s++) begin
        logic [7:0]  op;
        logic [31:0] imm;
        string       tg;
        if (hasl && s == 3) break;
        op  = w[31-8*s -: 8];
        imm = 0;
        tg  = (s == 0) ? entry_tag : "R2";
        if (op == 8'h02) begin
          q_fa.push_back(pc + 4 + 4*nl);
          q_ftag.push_back("R5");
          imm = rd(pc + 4 + 4*nl);
          nl++;
          tg = "R5";
        end else if (op == 8'h01) begin
          imm = (s == 3) ? 32'h0 : {24'h0, w[7:0]};
          tg  = (s == 3) ? "R4" : "R3";
        end else if (op != 8'h00) begin
          tg = (s == 0) ? entry_tag : "R4";
        end
        q_op.push_back(op); q_imm.push_back(imm); q_slot.push_back(s);
        q_ga.push_back(pc); q_tag.push_back(tg);
        niss++;
        if (op == 8'h03) begin
          taken = (brn % 2 == 0);
          if (taken) pc = tgt_of(brn) & ~32'h3;
          brn++;
          if (taken) break;
          entry_tag = "R8";
        end
      end
      if (!taken) begin
        pc = pc + 4 + 4*nl;
        entry_tag = "R6";
      end else begin
        entry_tag = "R7";
      end
    end
  endtask

  // memory with 0..3 cycle latency, idle at least one cycle between responses
  bit          busy = 0;
  int          wt = 0;
  int          lat_ctr = 0;
  logic [31:0] req_addr = '0;
  int          brn_tb = 0;

  always @(negedge clk) begin
    if (rst) begin
      mem_rvalid = 1'b0;
      busy = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      busy = 0;
    end else if (mem_req) begin
      if (!busy) begin
        busy = 1;
        wt = (lat_ctr * 7 + 3) % 4;
        lat_ctr++;
        req_addr = mem_addr;
        if (q_fa.size() > 0 && seen < NISS) begin
          check(mem_addr == q_fa[0], q_ftag[0], "fetch address", mem_addr, q_fa[0]);
          void'(q_fa.pop_front());
          void'(q_ftag.pop_front());
        end
      end else begin
        // R1: address held while waiting
        check(mem_addr == req_addr, "R1", "held address", mem_addr, req_addr);
      end
      if (wt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd(mem_addr);
      end else begin
        wt--;
      end
    end
  end

  // compare issue port every clock; drive branch outcome after a branch issue
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      br_taken = 1'b0;
      if (iss_valid && seen < NISS) begin
        if (q_op.size() == 0) begin
          check(0, "R2", "unexpected issue", {24'h0, iss_op}, 32'h0);
        end else begin
          check(iss_op == q_op[0], q_tag[0], "opcode", {24'h0, iss_op}, {24'h0, q_op[0]});
          check(iss_imm == q_imm[0], q_tag[0], "immediate", iss_imm, q_imm[0]);
          check(int'(iss_slot) == q_slot[0], q_tag[0], "slot", {30'h0, iss_slot}, q_slot[0]);
          check(iss_gaddr == q_ga[0], q_tag[0], "group address", iss_gaddr, q_ga[0]);
          void'(q_op.pop_front()); void'(q_imm.pop_front());
          void'(q_slot.pop_front()); void'(q_ga.pop_front()); void'(q_tag.pop_front());
        end
        seen++;
        if (iss_op == 8'h03) begin
          br_taken  = (brn_tb % 2 == 0);
          br_target = tgt_of(brn_tb);
          brn_tb++;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ram[i] = 32'h0;
    ram[0]  = 32'h11_01_00_5A;  // ALU, load-byte slot1, nop; data 5A
    ram[1]  = 32'h02_12_02_13;  // two load-words
    ram[2]  = 32'hDEADBEEF;
    ram[3]  = 32'h01234567;
    ram[4]  = 32'h02_02_02_02;  // four load-words
    ram[5]  = 32'hA0A0A0A0;
    ram[6]  = 32'hB1B1B1B1;
    ram[7]  = 32'hC2C2C2C2;
    ram[8]  = 32'hD3D3D3D3;
    ram[9]  = 32'h11_03_12_77;  // branch in slot 1, passthrough 77
    ram[10] = 32'h13_02_00_00;  // load-word then nops
    ram[11] = 32'h55667788;
    ram[12] = 32'h22_02_03_01;  // branch slot 2, load-byte in slot 3
    ram[13] = 32'h0BADF00D;
    ram[14] = 32'h01_02_01_C3;  // load-bytes around a load-word
    ram[15] = 32'hFEEDFACE;
    ram[16] = 32'h03_11_11_11;  // branch in slot 0
    ram[18] = 32'h14_03_15_16;  // branch in slot 1
    build_model();

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(iss_valid == 1'b0, "R9", "no issue in reset", {31'h0, iss_valid}, 32'h0);
    check(mem_req == 1'b1 && mem_addr == 32'h0, "R9", "first fetch address", mem_addr, 32'h0);
    rst = 1'b0;

    while (seen < NISS && cyc < 20000) @(posedge clk);
    @(negedge clk);
    if (seen < NISS) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d issues expected %0d", seen, NISS);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule